// File: doc/BRIEF.md
# Carry-Save Multiply-Accumulate Accumulator

This block is the accumulation stage of a multiply-accumulate datapath. An upstream multiplier hands it each product still split into two vectors, a partial sum and a partial carry, whose ordinary sum is the product. On every cycle in which the accumulate strobe is high, the block folds that pair into a running total. The total is also kept as a pair of registers, a sum row and a carry row. The fold uses two levels of 3:2 compressors and nothing else, so no carry ever travels across the word inside the feedback loop.

Carries are settled only when a resolve request arrives. A single carry-propagate adder then adds the two stored rows. The exact total is registered together with an overflow flag and marked valid on the following cycle. The accumulator is wider than the product by a set of guard bits and wraps modulo 2^ACC_W. Every carry pushed off the top of either row, and the carry out of the final add, is remembered so that the overflow flag reports whether the true unbounded sum has left the range. Sign and range are judged only on the settled value.

Top module: `csa_mac_acc`

## Requirements
- R1: After a synchronous active-low reset, result, result_valid and overflow are 0 and the accumulated total is 0.
- R2: In a cycle with acc_en high and clr low, the total grows by ps_in + pc_in, both read as unsigned PROD_W-bit values and zero-extended to ACC_W bits.
- R3: In a cycle with acc_en and clr both low, the total is unchanged.
- R4: In a cycle with clr high, the total and its overflow history are discarded. If acc_en is also high, the new total is ps_in + pc_in; otherwise it is 0.
- R5: A resolve in cycle t makes result_valid high in cycle t+1 only. result in that cycle equals the total, modulo 2^ACC_W, of all accumulations accepted before cycle t.
- R6: An accumulation accepted in the same cycle as a resolve is not part of that resolve's result but is included in every later one.
- R7: overflow, valid with result, is 1 exactly when the unbounded sum of the products accepted since the last clear (or reset) is at least 2^ACC_W.
- R8: result and overflow keep their values in every cycle that follows a cycle without resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Discard the running total (and load the product if acc_en is high) |
| acc_en | input | 1 | Accept the product pair this cycle |
| ps_in | input | PROD_W | Partial-sum vector of the product |
| pc_in | input | PROD_W | Partial-carry vector of the product, same weight as ps_in |
| resolve | input | 1 | Request a carry-propagated read of the total |
| result | output | ACC_W | Settled total modulo 2^ACC_W |
| result_valid | output | 1 | High for one cycle after each resolve |
| overflow | output | 1 | Unbounded total since last clear reached 2^ACC_W |

## Verification
Random small product pairs with sparse resolves test whether the redundant rows keep the right total across many folds. Saturated pairs (all ones in both vectors) drive carries off the top of both rows. This separates a correct wrap-and-flag result from a result that loses the dropped carries, and a clear afterwards shows whether the flag history is discarded. Resolves placed in the same cycle as an accumulation or a clear separate read-before-update from read-after-update ordering. Idle stretches show whether the rows drift without acc_en.

// File: rtl/csmac_pkg.sv
// Package: default sizes shared by the carry-save accumulator and its bench.
// Assumes nothing beyond the widths being positive.
package csmac_pkg;
    localparam int CSM_PROD_W_DEF  = 16;  // width of each product vector
    localparam int CSM_GUARD_W_DEF = 8;   // headroom bits above the product
endpackage

// File: rtl/csa_row.sv
// Module: one row of independent full adders (3:2 compressor).
// Outputs the per-bit sum and the per-bit majority carry, not yet shifted.
// Assumes the caller applies the one-place weight to the carry row.
module csa_row #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cy_o
);
    // One full adder per bit position; no connection between positions.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = in_a[i] ^ in_b[i] ^ in_c[i];
        assign cy_o[i]  = (in_a[i] & in_b[i]) | (in_b[i] & in_c[i]) | (in_a[i] & in_c[i]);
    end
endmodule

// File: rtl/csa_4to2.sv
// Module: four-operand to two-operand reduction from two 3:2 rows.
// The carry rows are shifted up one place. A carry leaving bit W-1 is
// reported on spill_o so that the caller can keep track of it.
// Assumes all four operands have equal weight.
module csa_4to2 #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_w,
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic [W-1:0] op_z,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] car_o,
    output logic         spill_o
);
    logic [W-1:0] lvl1_s, lvl1_c, lvl1_cs;
    logic [W-1:0] lvl2_s, lvl2_c;

    // First level: three operands to a sum row and a raw carry row.
    csa_row #(.W(W)) u_lvl1 (
        .in_a (op_w), .in_b (op_x), .in_c (op_y),
        .sum_o(lvl1_s), .cy_o(lvl1_c)
    );

    // Weight the first carry row one place up.
    assign lvl1_cs = {lvl1_c[W-2:0], 1'b0};

    // Second level: fold in the fourth operand.
    csa_row #(.W(W)) u_lvl2 (
        .in_a (lvl1_s), .in_b (lvl1_cs), .in_c (op_z),
        .sum_o(lvl2_s), .cy_o(lvl2_c)
    );

    // Outputs: shifted carry row and the carries that fell off the top.
    assign sum_o   = lvl2_s;
    assign car_o   = {lvl2_c[W-2:0], 1'b0};
    assign spill_o = lvl1_c[W-1] | lvl2_c[W-1];
endmodule

// File: rtl/cpa_add.sv
// Module: carry-propagate adder for the resolve path, with carry out.
// Not part of the accumulate loop; it runs only on the stored rows.
module cpa_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    // Full-width addition with one extra bit for the carry out.
    assign {cout_o, sum_o} = {1'b0, a_in} + {1'b0, b_in};
endmodule

// File: rtl/csa_mac_acc.sv
// Module: carry-save accumulator for a multiply-accumulate path.
// Holds the total as a sum row and a carry row whose plain sum is the total.
// Each accepted product pair is folded in through a 4:2 reduction only.
// resolve settles the rows once and registers the result and overflow.
// Assumes product vectors are unsigned and of equal weight.
module csa_mac_acc
    import csmac_pkg::*;
#(
    parameter int PROD_W  = CSM_PROD_W_DEF,
    parameter int GUARD_W = CSM_GUARD_W_DEF,
    parameter int ACC_W   = PROD_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_en,
    input  logic [PROD_W-1:0] ps_in,
    input  logic [PROD_W-1:0] pc_in,
    input  logic              resolve,
    output logic [ACC_W-1:0]  result,
    output logic              result_valid,
    output logic              overflow
);
    localparam int EXT_W = ACC_W - PROD_W;

    logic [ACC_W-1:0] zs_q, zc_q;
    logic             wrap_q;
    logic [ACC_W-1:0] fb_s, fb_c, add_s, add_c;
    logic [ACC_W-1:0] nxt_s, nxt_c;
    logic             spill;
    logic [ACC_W-1:0] settled;
    logic             settled_cout;

    // Feedback operands: the stored rows, or zero when clearing.
    assign fb_s = clr ? '0 : zs_q;
    assign fb_c = clr ? '0 : zc_q;

    // New operands: the zero-extended product pair, or zero when not accepted.
    assign add_s = acc_en ? {{EXT_W{1'b0}}, ps_in} : '0;
    assign add_c = acc_en ? {{EXT_W{1'b0}}, pc_in} : '0;

    // Loop reduction: two compressor levels, no carry propagation.
    csa_4to2 #(.W(ACC_W)) u_red (
        .op_w   (fb_s),
        .op_x   (fb_c),
        .op_y   (add_s),
        .op_z   (add_c),
        .sum_o  (nxt_s),
        .car_o  (nxt_c),
        .spill_o(spill)
    );

    // Accumulator rows and sticky record of carries lost off the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zs_q   <= '0;
            zc_q   <= '0;
            wrap_q <= 1'b0;
        end else if (clr || acc_en) begin
            zs_q   <= nxt_s;
            zc_q   <= nxt_c;
            wrap_q <= (wrap_q & ~clr) | spill;
        end
    end

    // Resolve path: one carry-propagate add of the stored rows.
    cpa_add #(.W(ACC_W)) u_cpa (
        .a_in  (zs_q),
        .b_in  (zc_q),
        .sum_o (settled),
        .cout_o(settled_cout)
    );

    // Output register: capture the settled value and flag on resolve.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
            overflow     <= 1'b0;
        end else begin
            result_valid <= resolve;
            if (resolve) begin
                result   <= settled;
                overflow <= wrap_q | settled_cout;
            end
        end
    end
endmodule

// File: rtl/csa_mac_chk.sv
// Module: property checker for csa_mac_acc, attached through bind.
// Observes ports and the stored rows; drives nothing.
module csa_mac_chk #(
    parameter int ACC_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             acc_en,
    input logic             resolve,
    input logic [ACC_W-1:0] zs_q,
    input logic [ACC_W-1:0] zc_q,
    input logic             wrap_q,
    input logic [ACC_W-1:0] result,
    input logic             result_valid,
    input logic             overflow
);
    // R5: a resolve is answered by a valid strobe one cycle later.
    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resolve |=> result_valid);

    // R5: no valid strobe without a resolve in the previous cycle.
    assert_valid_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !resolve |=> !result_valid);

    // R8: the registered answer holds between resolves.
    assert_output_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !resolve |=> ($stable(result) && $stable(overflow)));

    // R3: the stored rows do not move while idle.
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !clr) |=> ($stable(zs_q) && $stable(zc_q)));

    // R4: a plain clear leaves empty rows and no overflow history.
    assert_clear_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !acc_en) |=> (zs_q == '0 && zc_q == '0 && !wrap_q));

    // R7: lost-carry history persists until a clear.
    assert_wrap_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_q && !clr) |=> wrap_q);
endmodule

bind csa_mac_acc csa_mac_chk #(.ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .acc_en      (acc_en),
    .resolve     (resolve),
    .zs_q        (zs_q),
    .zc_q        (zc_q),
    .wrap_q      (wrap_q),
    .result      (result),
    .result_valid(result_valid),
    .overflow    (overflow)
);

// File: tb/sim_csa_mac_acc.sv
// Bench: behavioural reference total in a wide integer, compared every clock.
module sim_csa_mac_acc;
    localparam int  PW = 16;
    localparam int  GW = 8;
    localparam int  AW = PW + GW;
    localparam time CLK_PERIOD = 10;
    localparam longint unsigned LIMIT = 64'd1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          acc_en = 1'b0;
    logic          resolve = 1'b0;
    logic [PW-1:0] ps_in = '0;
    logic [PW-1:0] pc_in = '0;
    logic [AW-1:0] result;
    logic          result_valid;
    logic          overflow;

    csa_mac_acc #(.PROD_W(PW), .GUARD_W(GW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en),
        .ps_in(ps_in), .pc_in(pc_in), .resolve(resolve),
        .result(result), .result_valid(result_valid), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int              n_vec = 0;
    int              n_bad = 0;
    bit              done = 0;
    string           tag = "R1";
    longint unsigned ref_total = 0;
    logic [AW-1:0]   exp_res = '0;
    bit              exp_rv = 0;
    bit              exp_ovf = 0;

    // Reference model: read-before-update on resolve, unbounded total.
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_total = 0; exp_res = '0; exp_rv = 0; exp_ovf = 0;
        end else begin
            exp_rv = resolve;
            if (resolve) begin
                exp_res = AW'(ref_total % LIMIT);
                exp_ovf = (ref_total >= LIMIT);
            end
            if (clr)
                ref_total = acc_en ? (longint'(ps_in) + longint'(pc_in)) : 0;
            else if (acc_en)
                ref_total = ref_total + longint'(ps_in) + longint'(pc_in);
        end
    end

    task automatic compare();
        n_vec++;
        if (result_valid !== exp_rv || result !== exp_res || overflow !== exp_ovf) begin
            n_bad++;
            $display("FAIL %s: got rv=%0b result=%0h ovf=%0b, expected rv=%0b result=%0h ovf=%0b",
                     tag, result_valid, result, overflow, exp_rv, exp_res, exp_ovf);
        end
    endtask

    task automatic step(input bit c, input bit v, input bit r,
                        input logic [PW-1:0] a, input logic [PW-1:0] b);
        clr = c; acc_en = v; resolve = r; ps_in = a; pc_in = b;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        // R1: reset state, then a resolve straight after reset reads zero.
        tag = "R1";
        repeat (3) step(0, 0, 0, '0, '0);
        rst_n = 1'b1;
        step(0, 0, 1, '0, '0);
        step(0, 0, 0, '0, '0);

        // R2: random small product pairs, sparse resolves.
        tag = "R2";
        for (int i = 0; i < 60; i++)
            step(0, 1, (i % 7) == 6, PW'($urandom_range(0, 4095)), PW'($urandom_range(0, 4095)));
        step(0, 0, 1, '0, '0);
        step(0, 0, 0, '0, '0);

        // R3: idle cycles with inputs toggling but acc_en low.
        tag = "R3";
        for (int i = 0; i < 10; i++)
            step(0, 0, 0, PW'($urandom), PW'($urandom));
        step(0, 0, 1, '0, '0);
        step(0, 0, 0, '0, '0);

        // R4: plain clear, then clear together with a product.
        tag = "R4";
        step(1, 0, 0, 16'h1234, 16'h0F0F);
        step(0, 0, 1, '0, '0);
        step(0, 1, 0, 16'h0100, 16'h0001);
        step(1, 1, 0, 16'h00A5, 16'h005A);
        step(0, 0, 1, '0, '0);
        step(0, 0, 0, '0, '0);

        // R6: accumulate in the resolve cycle, and resolve during a clear.
        tag = "R6";
        step(0, 1, 1, 16'h0010, 16'h0020);
        step(0, 0, 1, '0, '0);
        step(1, 1, 1, 16'h0003, 16'h0004);
        step(0, 0, 1, '0, '0);
        step(0, 0, 0, '0, '0);

        // R7: saturated pairs push the total past 2^AW, then a clear.
        tag = "R7";
        step(1, 0, 0, '0, '0);
        for (int i = 0; i < 300; i++)
            step(0, 1, (i % 25) == 24, 16'hFFFF, 16'hFFFF);
        step(0, 0, 1, '0, '0);
        step(1, 0, 0, '0, '0);
        step(0, 0, 1, '0, '0);
        step(0, 0, 0, '0, '0);

        // R8: long random mix of all controls; outputs must hold between resolves.
        tag = "R8";
        for (int i = 0; i < 3000; i++)
            step(($urandom % 60) == 0, ($urandom % 4) != 0, ($urandom % 5) == 0,
                 PW'($urandom), PW'($urandom));
        step(0, 0, 1, '0, '0);
        step(0, 0, 0, '0, '0);

        done = 1;
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog: got no completion, expected completion");
            finish_run();
        end
    end
endmodule